// File: doc/BRIEF.md
# Random TLB Replacement Index Generator

This block supplies the slot number used when a translation entry must be replaced at random. It keeps a 32-bit seed that moves forward by a linear congruential step each time a new index is asked for. The upper half of the advanced seed is folded into the window of replaceable slots. That window starts at a programmable count of locked ("wired") low slots and ends at the top slot. The reduction uses a remainder unit that works one numerator bit per cycle, so a full result takes a fixed, short number of cycles.

A client raises `req_i` for one cycle while `busy_o` is low, with the slot count and the locked count on `entries_i` and `wired_i`. The block samples both counts at that edge and raises `busy_o`. Some cycles later it pulses `valid_o` for one cycle, with the new slot on `index_o`. `index_o` keeps that value until the next result. When the locked count leaves no window, the block returns the top slot at once and never divides.

Top module: `rndidx_gen`

## Requirements
- R1: After a synchronous reset the seed is 0, `busy_o` and `valid_o` are low and `index_o` is 0.
- R2: Each accepted request replaces the seed by (seed × 314159 + 1) mod 2^32. The first request after reset therefore uses seed 1.
- R3: The raw value is bits 31:16 of the advanced seed.
- R4: When wired < entries, `index_o` = (raw mod (entries − wired)) + wired. It always lies in [wired, entries − 1].
- R5: A request is accepted only when `busy_o` is low, and `busy_o` is high in the next cycle. For a non-degenerate request, `valid_o` is high for exactly one cycle, 17 clock edges after the accepting edge, and `busy_o` falls at that same edge.
- R6: A request made while `busy_o` is high is ignored. The seed does not advance and no extra result appears.
- R7: When wired ≥ entries, the result is entries − 1, or 0 if entries is 0. It appears with `valid_o` one edge after the accepting edge, and the seed still advances.
- R8: `entries_i` and `wired_i` are sampled only at the accepting edge. Changes while busy do not affect the result.
- R9: An `entries_i` value above 64 is treated as 64.
- R10: `index_o` holds its value in every cycle that is not a result cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request a new index (taken when busy_o is low) |
| entries_i | input | 7 | Number of slots, 0..64 |
| wired_i | input | 6 | Number of locked low slots |
| busy_o | output | 1 | A request is being worked on |
| valid_o | output | 1 | One-cycle pulse: index_o holds a new result |
| index_o | output | 6 | Selected slot |

## Verification
The bench runs a model of the seed sequence for locked counts of 0, 5, 17, 40 and 63, and for a one-slot window, where the result must equal the locked count. A design that shifted the wrong seed bits, or stepped the seed on the wrong rule, would diverge from the second result onward. It also covers the degenerate cases: locked equal to, above, and with zero slots. A design that divided there would return garbage or hang, and one that skipped the seed step would shift every later result. Requests and count changes are injected while the block is busy, and an over-range slot count is applied. A design that accepted such a request, or resampled the counts, would show an extra or shifted result or a slot outside the window. Arrival times are checked against 17 and 1 edges, and index holding is checked after results.

// File: rtl/rndidx_pkg.sv
package rndidx_pkg;

  // Linear congruential step constants
  localparam logic [31:0] LCG_MUL = 32'd314159;
  localparam logic [31:0] LCG_INC = 32'd1;

  function automatic logic [31:0] lcg_step(input logic [31:0] s);
    logic [63:0] prod;
    prod = {32'd0, s} * {32'd0, LCG_MUL};
    return prod[31:0] + LCG_INC;
  endfunction

endpackage

// File: rtl/rndidx_seed.sv
module rndidx_seed
  import rndidx_pkg::*;
#(
  parameter int SEED_W = 32,
  parameter int RAW_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [RAW_W-1:0] raw_nxt_o
);

  logic [SEED_W-1:0] seed_q;
  logic [SEED_W-1:0] seed_nxt;

  always_comb begin
    seed_nxt = lcg_step(seed_q);
  end

  assign raw_nxt_o = seed_nxt[SEED_W-1 -: RAW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q <= '0;
    end else if (step_i) begin
      seed_q <= seed_nxt;
    end
  end

  AST_SEED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(seed_q)); // R6

endmodule

// File: rtl/rndidx_window.sv
module rndidx_window #(
  parameter int IDX_W = 6,
  localparam int ENT_W = IDX_W + 1
) (
  input  logic [ENT_W-1:0] entries_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic [ENT_W-1:0] ent_sat_o,
  output logic [ENT_W-1:0] den_o,
  output logic             degen_o,
  output logic [IDX_W-1:0] clamp_o
);

  localparam logic [ENT_W-1:0] MAX_ENT = ENT_W'(1 << IDX_W);

  logic [ENT_W-1:0] wired_ext;

  always_comb begin
    wired_ext = {1'b0, wired_i};
    ent_sat_o = (entries_i > MAX_ENT) ? MAX_ENT : entries_i;
    degen_o   = (wired_ext >= ent_sat_o);
    den_o     = degen_o ? ENT_W'(1) : (ent_sat_o - wired_ext);
    clamp_o   = (ent_sat_o == '0) ? '0 : IDX_W'(ent_sat_o - ENT_W'(1));
  end

endmodule

// File: rtl/rndidx_moddiv.sv
module rndidx_moddiv #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 7,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             run_o,
  output logic             done_o,
  output logic [DEN_W-1:0] rem_o
);

  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  always_comb begin
    trial = {rem_q, num_q[NUM_W-1]};
    fits  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      den_q <= DEN_W'(1);
      rem_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      num_q <= num_i;
      den_q <= den_i;
      rem_q <= '0;
      cnt_q <= CNT_W'(NUM_W);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
        num_q <= num_q << 1;
        cnt_q <= cnt_q - CNT_W'(1);
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign run_o  = run_q;
  assign done_o = run_q && (cnt_q == '0);
  assign rem_o  = rem_q;

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (rem_q < den_q)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(NUM_W)); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (done_o && !load_i) |=> !run_q); // R5

endmodule

// File: rtl/rndidx_gen.sv
module rndidx_gen #(
  parameter int IDX_W  = 6,
  parameter int SEED_W = 32,
  parameter int RAW_W  = 16,
  localparam int ENT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [ENT_W-1:0] entries_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] index_o
);

  logic             accept;
  logic             finish;
  logic [RAW_W-1:0] raw_nxt;
  logic [ENT_W-1:0] ent_sat;
  logic [ENT_W-1:0] den;
  logic             degen;
  logic [IDX_W-1:0] clamp;
  logic             div_run;
  logic             div_done;
  logic [ENT_W-1:0] div_rem;

  logic             busy_q;
  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] wired_q;
  logic [ENT_W-1:0] ent_q;
  logic             degen_q;
  logic [IDX_W-1:0] clamp_q;

  assign accept = req_i && !busy_q;
  assign finish = busy_q && (degen_q || div_done);

  rndidx_seed #(
    .SEED_W(SEED_W),
    .RAW_W (RAW_W)
  ) i_seed (
    .clk      (clk),
    .rst      (rst),
    .step_i   (accept),
    .raw_nxt_o(raw_nxt)
  );

  rndidx_window #(
    .IDX_W(IDX_W)
  ) i_window (
    .entries_i(entries_i),
    .wired_i  (wired_i),
    .ent_sat_o(ent_sat),
    .den_o    (den),
    .degen_o  (degen),
    .clamp_o  (clamp)
  );

  rndidx_moddiv #(
    .NUM_W(RAW_W),
    .DEN_W(ENT_W)
  ) i_moddiv (
    .clk   (clk),
    .rst   (rst),
    .load_i(accept && !degen),
    .num_i (raw_nxt),
    .den_i (den),
    .run_o (div_run),
    .done_o(div_done),
    .rem_o (div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      wired_q <= '0;
      ent_q   <= '0;
      degen_q <= 1'b0;
      clamp_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        wired_q <= wired_i;
        ent_q   <= ent_sat;
        degen_q <= degen;
        clamp_q <= clamp;
      end else if (finish) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
        idx_q   <= degen_q ? clamp_q
                           : IDX_W'(div_rem + {1'b0, wired_q});
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign index_o = idx_q;

  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !busy_o); // R5
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_i && !busy_o) |=> busy_o); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_DIV_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !div_run); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(index_o)); // R10
  AST_IDX_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !degen_q) |-> ((index_o >= wired_q) && ({1'b0, index_o} < ent_q))); // R4
  AST_DEGEN_TOP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && degen_q && (ent_q != '0)) |-> ({1'b0, index_o} == ent_q - ENT_W'(1))); // R7

endmodule

// File: tb/test_rndidx_gen.sv
module test_rndidx_gen;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int ENT_W = IDX_W + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_i = 1'b0;
  logic [ENT_W-1:0] entries_i = '0;
  logic [IDX_W-1:0] wired_i = '0;
  logic             busy_o;
  logic             valid_o;
  logic [IDX_W-1:0] index_o;

  rndidx_gen i_rndidx_gen (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .entries_i(entries_i),
    .wired_i  (wired_i),
    .busy_o   (busy_o),
    .valid_o  (valid_o),
    .index_o  (index_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0]      m_seed = 32'd0;
  logic [IDX_W-1:0] last_idx = '0;

  logic [IDX_W-1:0] q_idx[$];
  int               q_due[$];
  string            q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [IDX_W-1:0] model_idx(input logic [31:0] s,
      input logic [ENT_W-1:0] e, input logic [IDX_W-1:0] w);
    int es;
    int raw;
    es  = (e > 64) ? 64 : int'(e);
    raw = int'(s[31:16]);
    if (int'(w) >= es) return (es == 0) ? '0 : IDX_W'(es - 1);
    return IDX_W'((raw % (es - int'(w))) + int'(w));
  endfunction

  // Driver: issue one request; optionally disturb inputs while busy
  task automatic issue(input logic [ENT_W-1:0] e, input logic [IDX_W-1:0] w,
                       input bit poke, input string tag);
    bit dg;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    m_seed = m_seed * 32'd314159 + 32'd1;
    dg = (int'(w) >= ((e > 64) ? 64 : int'(e)));
    q_idx.push_back(model_idx(m_seed, e, w));
    q_due.push_back(cyc + (dg ? 2 : 18));
    q_tag.push_back(tag);
    req_i     = 1'b1;
    entries_i = e;
    wired_i   = w;
    @(negedge clk);
    req_i = 1'b0;
    if (poke && !dg) begin
      // R6 R8: requests and count changes while busy must be ignored
      repeat (3) begin
        req_i     = 1'b1;
        entries_i = 7'd9;
        wired_i   = 6'd3;
        @(negedge clk);
      end
      req_i = 1'b0;
    end
  endtask

  // Monitor: pop expected results and compare value and arrival cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        if (q_idx.size() == 0) begin
          chk(1'b0, "R6", "unexpected result", int'(index_o), -1);
        end else begin
          chk(index_o == q_idx[0], q_tag[0], "index", int'(index_o), int'(q_idx[0]));
          chk(cyc == q_due[0], "R5", "arrival cycle", cyc, q_due[0]);
          void'(q_idx.pop_front());
          void'(q_due.pop_front());
          void'(q_tag.pop_front());
        end
        last_idx <= index_o;
      end else if (q_idx.size() > 0 && cyc > q_due[0]) begin
        chk(1'b0, "R5", "result late", cyc, q_due[0]);
        void'(q_idx.pop_front());
        void'(q_due.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    chk(valid_o == 1'b0, "R1", "valid after reset", int'(valid_o), 0);
    chk(index_o == '0, "R1", "index after reset", int'(index_o), 0);
    rst = 1'b0;

    // R2 R3 R4: sequences for several locked counts with 64 slots
    for (int k = 0; k < 12; k++) issue(7'd64, 6'd0, 1'b0, "R2 R3 R4");
    for (int k = 0; k < 12; k++) issue(7'd64, 6'd5, 1'b0, "R4");
    for (int k = 0; k < 12; k++) issue(7'd64, 6'd17, 1'b0, "R4");
    for (int k = 0; k < 10; k++) issue(7'd64, 6'd40, 1'b0, "R4");
    for (int k = 0; k < 6; k++)  issue(7'd64, 6'd63, 1'b0, "R4");
    for (int k = 0; k < 10; k++) issue(7'd48, 6'd10, 1'b0, "R4");
    for (int k = 0; k < 5; k++)  issue(7'd33, 6'd32, 1'b0, "R4");

    // R9: over-range slot count
    for (int k = 0; k < 8; k++)  issue(7'd100, 6'd8, 1'b0, "R9");

    // R7: degenerate windows, seed still advances
    issue(7'd20, 6'd20, 1'b0, "R7");
    issue(7'd10, 6'd30, 1'b0, "R7");
    issue(7'd0,  6'd0,  1'b0, "R7");
    for (int k = 0; k < 4; k++) issue(7'd64, 6'd3, 1'b0, "R7");

    // R6 R8: disturbances while busy
    for (int k = 0; k < 8; k++) issue(7'd50, 6'd7, 1'b1, "R6 R8");

    // R10: index holds after a result
    @(negedge clk);
    while (busy_o || q_idx.size() > 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(index_o == last_idx, "R10", "index held", int'(index_o), int'(last_idx));
    chk(valid_o == 1'b0, "R10", "no stray valid", int'(valid_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule